// File: doc/BRIEF.md
# Strobe-Sequenced DRAM Controller with Timed Refresh

This block lets synchronous logic use an asynchronous DRAM. The requester holds a request (valid, write flag, full word address, write data) until the controller pulses `done`. The controller takes the request only when it is idle and copies all of its fields at that moment. It then drives the memory through the active-low strobe pins. The row half of the address goes out on a half-width address bus and is qualified by the row strobe. Then the column half goes out and is qualified by the column strobe. For a read, the controller captures the data bus just before releasing the column strobe, and `done` rises with the result.

An interval timer inside the block asks for a refresh at a fixed period. The refresh uses the CAS-before-RAS order, so no address is needed. A refresh that is pending always wins over a waiting request. Every pulse width is a parameter counted in clock cycles: row-to-column delay, column width, minimum row-active time, precharge time and refresh interval.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, all four strobes (`row_strobe_n`, `col_strobe_n`, `write_n`, `out_en_n`) are high, `done` is low and `mem_dout_en` is low.
- R2: An access begins with a falling `row_strobe_n` while `col_strobe_n` is high. In that cycle `mem_addr` carries the upper half of the captured address, `req_addr[2*MA_W-1:MA_W]`.
- R3: In an access, `col_strobe_n` falls exactly T_RCD cycles after `row_strobe_n` falls. In that cycle `mem_addr` carries the lower half, `req_addr[MA_W-1:0]`.
- R4: While the column strobe is low in a write, `write_n` is low, `mem_dout_en` is high and `out_en_n` stays high for the whole pulse.
- R5: In a read, `write_n` is high, `out_en_n` is low and `mem_dout_en` is low. The column strobe stays low for T_CAS cycles. `rd_data` takes the `mem_din` value seen in the last low cycle. `done` is high for exactly one cycle, the first cycle with the column strobe released.
- R6: The row strobe stays low for at least T_RAS cycles in every access and every refresh. In an access it is not released while the column strobe is still low.
- R7: Between any two low periods, the row strobe stays high for at least T_RP cycles.
- R8: A refresh lowers `col_strobe_n` one cycle before `row_strobe_n`. During a refresh `write_n` and `out_en_n` are high and `mem_dout_en` is low. Both strobes are released in the same cycle.
- R9: The controller requests a refresh every T_REFI clock cycles, counted from reset. With no traffic, successive refreshes start exactly T_REFI cycles apart.
- R10: Once a refresh is pending, no access starts until that refresh has started.
- R11: A request is captured only when the controller is idle. Changes to `req_addr`, `req_wdata` or `req_write` after capture have no effect on the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA_W | Word address; upper half is the row, lower half is the column |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read result, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| row_strobe_n | output | 1 | Active-low row address strobe |
| col_strobe_n | output | 1 | Active-low column address strobe |
| write_n | output | 1 | Low selects write |
| out_en_n | output | 1 | Low lets the memory drive data |
| mem_addr | output | MA_W | Multiplexed row/column address |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_dout_en | output | 1 | Controller drives the data bus |
| mem_din | input | DATA_W | Data from the memory |

## Verification
The memory model in the bench makes read data valid only in the final low cycle of the column strobe. A capture one cycle early or late returns the inverted word. The bench keeps its own refresh schedule from the reset edge count. An access that slips in ahead of an owed refresh is flagged, and so is an idle refresh spacing that drifts from the interval. It changes the request pins while an access is in flight, so a controller that samples them late writes the wrong cell or the wrong data. Writes and reads go to both extremes of the row and column halves, which exposes a swapped or shifted address split.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACT  = 3'd1,
    ST_COL  = 3'd2,
    ST_HOLD = 3'd3,
    ST_PRE  = 3'd4,
    ST_RCAS = 3'd5,
    ST_RRAS = 3'd6
  } seq_state_e;

  // Extra row-active cycles needed after the column pulse to reach the minimum
  function automatic int unsigned hold_len(int unsigned t_ras, int unsigned t_rcd,
                                           int unsigned t_cas);
    return (t_ras > t_rcd + t_cas) ? (t_ras - t_rcd - t_cas) : 0;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits to hold values 0 .. n-1
  function automatic int unsigned bits_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
  import dram_seq_pkg::*;
#(
  parameter int unsigned T_REFI = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);

  localparam int unsigned TW = bits_for(T_REFI);
  localparam logic [TW-1:0] LAST = TW'(T_REFI - 1);

  logic [TW-1:0] tick_q;
  logic          wrap;

  assign wrap = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend   <= 1'b0;
    end else begin
      tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // R9: interval expiry must leave a refresh pending
  a_r9_wrap_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend);

  // R10: the sequencer only takes a refresh that is pending
  a_r10_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int unsigned MA_W = 8
) (
  input  logic              row_sel,
  input  logic              col_sel,
  input  logic [2*MA_W-1:0] addr,
  output logic [MA_W-1:0]   ma
);

  function automatic logic [MA_W-1:0] row_part(logic [2*MA_W-1:0] a);
    return a[2*MA_W-1:MA_W];
  endfunction

  function automatic logic [MA_W-1:0] col_part(logic [2*MA_W-1:0] a);
    return a[MA_W-1:0];
  endfunction

  always_comb begin
    if (col_sel)      ma = col_part(addr);
    else if (row_sel) ma = row_part(addr);
    else              ma = '0;
  end

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic op_wr,
  input  logic ref_pend,
  output logic ref_ack,
  output logic accept,
  output logic col_last,
  output logic row_sel,
  output logic col_sel,
  output logic dq_drive,
  output logic row_stb_n,
  output logic col_stb_n,
  output logic wr_n,
  output logic oe_n
);

  localparam int unsigned HOLD_C = hold_len(T_RAS, T_RCD, T_CAS);
  localparam int unsigned LMAX   = max_of4(T_RCD, T_CAS, T_RAS, T_RP);
  localparam int unsigned CNT_W  = bits_for(LMAX + 1);
  localparam logic [CNT_W-1:0] L_ACT  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_COL  = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] L_HOLD = CNT_W'((HOLD_C == 0) ? 0 : HOLD_C - 1);
  localparam logic [CNT_W-1:0] L_PRE  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_RRAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] SAT_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] SAT_RAS = CNT_W'(T_RAS);

  seq_state_e       state_q, nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             seg_end;

  always_comb begin
    case (state_q)
      ST_ACT:  seg_end = (cnt_q == L_ACT);
      ST_COL:  seg_end = (cnt_q == L_COL);
      ST_HOLD: seg_end = (cnt_q == L_HOLD);
      ST_PRE:  seg_end = (cnt_q == L_PRE);
      ST_RRAS: seg_end = (cnt_q == L_RRAS);
      default: seg_end = 1'b1;
    endcase
  end

  always_comb begin
    nxt     = state_q;
    ref_ack = 1'b0;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          nxt     = ST_RCAS;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          nxt    = ST_ACT;
          accept = 1'b1;
        end
      end
      ST_ACT:  if (seg_end) nxt = ST_COL;
      ST_COL:  if (seg_end) nxt = (HOLD_C > 0) ? ST_HOLD : ST_PRE;
      ST_HOLD: if (seg_end) nxt = ST_PRE;
      ST_PRE:  if (seg_end) nxt = ST_IDLE;
      ST_RCAS: nxt = ST_RRAS;
      ST_RRAS: if (seg_end) nxt = ST_PRE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt;
      if (nxt != state_q || state_q == ST_IDLE) cnt_q <= '0;
      else                                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign col_last  = (state_q == ST_COL) && seg_end;
  assign row_sel   = (state_q == ST_ACT);
  assign col_sel   = (state_q == ST_COL);
  assign dq_drive  = (state_q == ST_COL) && op_wr;
  assign row_stb_n = !((state_q == ST_ACT) || (state_q == ST_COL) ||
                       (state_q == ST_HOLD) || (state_q == ST_RRAS));
  assign col_stb_n = !((state_q == ST_COL) || (state_q == ST_RCAS) ||
                       (state_q == ST_RRAS));
  assign wr_n      = !((state_q == ST_COL) && op_wr);
  assign oe_n      = !((state_q == ST_COL) && !op_wr);

  // Checker counters: consecutive cycles with the row strobe high / low
  logic [CNT_W-1:0] ras_hi_q, ras_lo_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_q <= SAT_RP;
      ras_lo_q <= '0;
    end else if (row_stb_n) begin
      ras_lo_q <= '0;
      if (ras_hi_q < SAT_RP) ras_hi_q <= ras_hi_q + 1'b1;
    end else begin
      ras_hi_q <= '0;
      if (ras_lo_q < SAT_RAS) ras_lo_q <= ras_lo_q + 1'b1;
    end
  end

  // R7: precharge time met before each new row strobe
  a_r7_precharge_met: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> (ras_hi_q >= SAT_RP));

  // R6: row strobe low for at least the minimum active time
  a_r6_active_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb_n) |-> (ras_lo_q >= SAT_RAS));

  // R8: refresh row strobe only falls with the column strobe already low
  a_r8_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(row_stb_n) && !col_stb_n) |-> $past(!col_stb_n));

  // R4: output enable kept off while writing
  a_r4_oe_off_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> oe_n);

endmodule

// File: rtl/dram_data_path.sv
module dram_data_path #(
  parameter int unsigned MA_W   = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              col_last,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              op_wr,
  output logic [2*MA_W-1:0] op_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_wr   <= 1'b0;
      op_addr <= '0;
      dq_out  <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        op_wr   <= req_write;
        op_addr <= req_addr;
        dq_out  <= req_wdata;
      end
      if (col_last && !op_wr) rdata <= dq_in;
      done <= col_last;
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int unsigned MA_W   = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RAS  = 6,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_REFI = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              row_strobe_n,
  output logic              col_strobe_n,
  output logic              write_n,
  output logic              out_en_n,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);

  logic              ref_pend, ref_ack, accept, col_last;
  logic              row_sel, col_sel, op_wr;
  logic [2*MA_W-1:0] op_addr;

  dram_refresh_timer #(.T_REFI(T_REFI)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  dram_strobe_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .op_wr    (op_wr),
    .ref_pend (ref_pend),
    .ref_ack  (ref_ack),
    .accept   (accept),
    .col_last (col_last),
    .row_sel  (row_sel),
    .col_sel  (col_sel),
    .dq_drive (mem_dout_en),
    .row_stb_n(row_strobe_n),
    .col_stb_n(col_strobe_n),
    .wr_n     (write_n),
    .oe_n     (out_en_n)
  );

  dram_data_path #(.MA_W(MA_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .col_last (col_last),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_in    (mem_din),
    .op_wr    (op_wr),
    .op_addr  (op_addr),
    .dq_out   (mem_dout),
    .rdata    (rd_data),
    .done     (done)
  );

  dram_addr_mux #(.MA_W(MA_W)) u_amux (
    .row_sel(row_sel),
    .col_sel(col_sel),
    .addr   (op_addr),
    .ma     (mem_addr)
  );

  // R5: done appears exactly as the column strobe is released
  a_r5_done_at_cas_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (col_strobe_n && $past(!col_strobe_n)));

endmodule

// File: tb/dram_seq_ctrl_test.sv
`timescale 1ns/100ps
module dram_seq_ctrl_test;
  localparam int MA_W = 8, DATA_W = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_RAS = 6, T_RP = 3, T_REFI = 200;
  localparam int ADDR_W = 2 * MA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, mem_din = '0;
  logic [DATA_W-1:0] rd_data, mem_dout;
  logic done, row_strobe_n, col_strobe_n, write_n, out_en_n, mem_dout_en;
  logic [MA_W-1:0] mem_addr;

  always #2.5 clk = ~clk;

  dram_seq_ctrl #(.MA_W(MA_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
                  .T_RAS(T_RAS), .T_RP(T_RP), .T_REFI(T_REFI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .write_n(write_n),
    .out_en_n(out_en_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  int nvec = 0, nfail = 0, cyc = 0;

  function automatic void check(bit ok, string tag, longint act, longint exp, string what);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  function automatic logic [DATA_W-1:0] fill(int k);
    return DATA_W'(k * 37 + 451);
  endfunction

  // Bench-side refresh schedule
  int edge_no = 0;
  bit arm = 0, owed = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      edge_no++;
      if (arm) owed = 1;
      arm = ((edge_no % T_REFI) == 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      report();
      $finish;
    end
  end

  // Request bookkeeping (bench side)
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [DATA_W-1:0] cur_wdata = '0;
  bit cur_wr = 0;

  // Behavioural memory and protocol monitor
  logic [DATA_W-1:0] mem [int];
  bit p_ras = 1, p_cas = 1, in_ref = 0, in_acc = 0, acc_wr = 0, was_acc = 0, acc_rise = 0;
  int hi_len = 1000, lo_len = 0, ras_fall_edge = 0, cas_fall_edge = 0, cas_lo_cnt = 0;
  int last_ref_edge = -1, ref_cnt = 0, done_cnt = 0, acc_cnt = 0;
  bit acc_since_ref = 0;
  logic [MA_W-1:0] row_q = '0, col_q = '0;
  logic [DATA_W-1:0] exp_rd = '0, last_rd = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      check(row_strobe_n && col_strobe_n && write_n && out_en_n, "R1",
            {row_strobe_n, col_strobe_n, write_n, out_en_n}, 4'hf, "strobes in reset");
      check(!done && !mem_dout_en, "R1", {done, mem_dout_en}, 0, "done/drive in reset");
    end else begin
      was_acc  = in_acc;
      acc_rise = was_acc && !p_cas && col_strobe_n;
      if (p_ras && !row_strobe_n) begin
        check(hi_len >= T_RP, "R7", hi_len, T_RP, "precharge cycles");
        if (!col_strobe_n) begin
          check(!p_cas, "R8", p_cas, 0, "column strobe leads row strobe");
          in_ref = 1; ref_cnt++;
        end else begin
          check(!owed, "R10", owed, 0, "access started while refresh owed");
          in_acc = 1; acc_since_ref = 1; acc_cnt++;
          ras_fall_edge = edge_no; row_q = mem_addr; acc_wr = cur_wr;
          check(mem_addr == cur_addr[ADDR_W-1:MA_W], "R2", mem_addr,
                cur_addr[ADDR_W-1:MA_W], "row address");
        end
        lo_len = 1;
      end else if (!p_ras && row_strobe_n) begin
        check(lo_len >= T_RAS, "R6", lo_len, T_RAS, "row strobe width");
        if (in_ref) check(!p_cas && col_strobe_n, "R8", {p_cas, col_strobe_n}, 2'b01,
                          "strobes released together");
        if (in_acc) check(col_strobe_n, "R6", col_strobe_n, 1, "row released before column");
        in_ref = 0; in_acc = 0; hi_len = 1;
      end else if (row_strobe_n) hi_len++;
      else lo_len++;

      if (in_ref) check(!mem_dout_en, "R8", mem_dout_en, 0, "bus driven in refresh");

      if (p_cas && !col_strobe_n) begin
        if (row_strobe_n) begin
          check(write_n && out_en_n && !mem_dout_en, "R8",
                {write_n, out_en_n, mem_dout_en}, 3'b110, "refresh controls");
          if (last_ref_edge >= 0 && !acc_since_ref)
            check(edge_no - last_ref_edge == T_REFI, "R9", edge_no - last_ref_edge,
                  T_REFI, "idle refresh spacing");
          last_ref_edge = edge_no; acc_since_ref = 0; owed = 0;
        end else begin
          check(edge_no - ras_fall_edge == T_RCD, "R3", edge_no - ras_fall_edge, T_RCD,
                "row-to-column delay");
          col_q = mem_addr;
          check(mem_addr == cur_addr[MA_W-1:0], "R3", mem_addr, cur_addr[MA_W-1:0],
                "column address");
          cas_fall_edge = edge_no; cas_lo_cnt = 1;
          if (acc_wr) begin
            check(!write_n && out_en_n && mem_dout_en, "R4",
                  {write_n, out_en_n, mem_dout_en}, 3'b011, "write controls");
            check(mem_dout == cur_wdata, "R11", mem_dout, cur_wdata, "write data");
            mem[int'({row_q, col_q})] = mem_dout;
          end else begin
            check(write_n && !out_en_n && !mem_dout_en, "R5",
                  {write_n, out_en_n, mem_dout_en}, 3'b100, "read controls");
            exp_rd = mem.exists(int'({row_q, col_q})) ? mem[int'({row_q, col_q})]
                                                      : fill(int'({row_q, col_q}));
          end
          mem_din = (cas_lo_cnt == T_CAS) ? exp_rd : ~exp_rd;
        end
      end else if (!col_strobe_n && !row_strobe_n && in_acc) begin
        cas_lo_cnt++;
        if (acc_wr) check(!write_n && out_en_n && mem_dout_en, "R4",
                          {write_n, out_en_n, mem_dout_en}, 3'b011, "write controls held");
        mem_din = (cas_lo_cnt == T_CAS) ? exp_rd : ~exp_rd;
      end

      if (acc_rise) begin
        check(edge_no - cas_fall_edge == T_CAS, "R5", edge_no - cas_fall_edge, T_CAS,
              "column strobe width");
        mem_din = ~exp_rd;
      end
      check(done == acc_rise, "R5", done, acc_rise, "done timing");
      if (done) begin
        done_cnt++;
        last_rd = rd_data;
        if (!acc_wr) check(rd_data == exp_rd, "R5", rd_data, exp_rd, "read data capture");
      end
      p_ras = row_strobe_n; p_cas = col_strobe_n;
    end
  end

  logic [DATA_W-1:0] shadow [int];

  task automatic access(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit scramble);
    int start_done, start_acc;
    @(posedge clk); #1;
    cur_wr = wr; cur_addr = a; cur_wdata = d;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    start_done = done_cnt; start_acc = acc_cnt;
    while (done_cnt == start_done) begin
      @(posedge clk); #1;
      if (scramble && acc_cnt != start_acc) begin
        req_addr = ~a; req_wdata = ~d; req_write = ~wr;
      end
    end
    req_valid = 1'b0;
    if (wr) shadow[int'(a)] = d;
  endtask

  task automatic read_expect(logic [ADDR_W-1:0] a, string tag);
    logic [DATA_W-1:0] e;
    access(1'b0, a, '0, 1'b0);
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : fill(int'(a));
    check(last_rd == e, tag, last_rd, e, "read back");
  endtask

  initial begin
    logic [ADDR_W-1:0] corners [6];
    corners = '{16'h0000, 16'hffff, 16'ha55a, 16'h00ff, 16'hff00, 16'h1234};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: quiet period, refreshes only
    repeat (3 * T_REFI + 20) @(posedge clk);
    #1 check(ref_cnt == 3, "R9", ref_cnt, 3, "refreshes in idle window");

    // R2 R3 R4: corner addresses written
    foreach (corners[i]) access(1'b1, corners[i], DATA_W'(16'h3c00 + i * 16'h0111), 1'b0);
    // R5: read back, plus never-written cells
    foreach (corners[i]) read_expect(corners[i], "R5");
    read_expect(16'h0f0f, "R5");

    // R11: pins disturbed while the access is in flight
    access(1'b1, 16'h4321, 16'hbeef, 1'b1);
    read_expect(16'h4321, "R11");
    read_expect(~16'h4321, "R11");
    access(1'b0, 16'h1234, '0, 1'b1);
    check(last_rd == shadow[int'(16'h1234)], "R11", last_rd, shadow[int'(16'h1234)],
          "read not redirected");

    // R10 R6 R7: back-to-back traffic spanning many refresh intervals
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(i * 40503 + 17) & 16'h0f3f;
      if (i % 3 != 2) access(1'b1, a, DATA_W'(i * 977 + 5), 1'b0);
      else read_expect(a, "R10");
    end
    check(ref_cnt >= edge_no / T_REFI - 1, "R9", ref_cnt, edge_no / T_REFI - 1,
          "refresh count under traffic");

    repeat (10) @(posedge clk);
    report();
    $finish;
  end

endmodule